// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps transitions on up to four external input lines. A single free-running counter, advanced by a programmable clock divider, is shared by every channel. Each channel resynchronises its input into the core clock domain, watches it for the kind of transition software has selected, and on a match copies the counter into its own capture register and raises its own status flag.

Software works the block through a simple word-addressed register port. Writes are single-cycle strobes and reads are combinational. A control word starts and stops the time base and sets its divider, and one word per channel selects the transition kind. Interrupt requests come from one enable mask and one status word, and status flags are cleared by writing ones to a separate acknowledge word. A sequencer outside this block turns pairs of timestamps into period or duty figures. The transition code is laid out so that XOR with 3 swaps rising and falling, which lets that sequencer alternate edges without a read-modify-write of the meaning.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset every readable register (control 0x50, interrupt mask 0x54, status 0x58, capture words 0x10+4n and transition-select words 0x30+4n) reads zero and `irq` is low.
- R2: The transition-select word of channel n at 0x30+4n holds a 2-bit code in bits [1:0]: 0 captures nothing, 1 captures low-to-high transitions, 2 captures high-to-low transitions, 3 captures both. The code reads back as written.
- R3: When a selected transition occurs, channel n's capture word at 0x10+4n takes the counter value present during the clock cycle just before the third rising clock edge after the input changes. Two of those edges are spent in the two-flop synchroniser.
- R4: Control bit 10 runs the counter, and control bits [8:4] hold a divider value P. While the counter runs it advances by one every P+1 clock cycles and wraps silently at its full width. While it is stopped it holds its value and the divider restarts from zero.
- R5: While control bit 10 is clear, no transition on any input changes a capture word or a status flag.
- R6: Channel n sets status bit n+1 at 0x58 when it captures. The interrupt mask at 0x54 uses the same bit positions [4:1]. `irq` is high exactly when some status bit and its mask bit are both set.
- R7: A write to 0x5C clears each status bit [4:1] whose data bit is one and leaves the others. Writing 0x1FF clears all of them, and writing zero clears none. When a capture and a clearing write hit the same channel in the same cycle, the flag stays set.
- R8: A capture on one channel leaves the capture words and status bits of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Byte address of the register accessed |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| cap_in | input | NUM_CH (4) | Asynchronous inputs to be timestamped |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the exact sample point of a capture. A synchroniser with one flop too many or too few, or a capture taken from the counter's next value, shows up as a timestamp off by one against an independent counter model. It runs every transition code, including the one that ignores everything and a swapped edge after an XOR flip, so that a wrong decode shows up as a spurious or missing timestamp. It lands an acknowledge on the same edge as a new capture: a design that lets the clear win loses that event's flag. It also runs the divider at a non-zero value and stops the time base. A divider that counts P instead of P+1, or a counter that keeps running or still captures while stopped, gives timestamps or flags that differ from the model.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    // Architectural limit on channels
    localparam int ECU_MAX_CH    = 4;

    // Register byte offsets (software decodes these)
    localparam int ECU_ADDR_CAP  = 'h10;
    localparam int ECU_ADDR_EDGE = 'h30;
    localparam int ECU_ADDR_CTRL = 'h50;
    localparam int ECU_ADDR_IEN  = 'h54;
    localparam int ECU_ADDR_STAT = 'h58;
    localparam int ECU_ADDR_ACK  = 'h5C;

    // Field positions
    localparam int ECU_RUN_BIT   = 10;
    localparam int ECU_PS_LSB    = 4;
    localparam int ECU_PS_W      = 5;
    localparam int ECU_FLAG_LSB  = 1;

    // Transition-select code; XOR with 3 swaps rise and fall
    typedef enum logic [1:0] {
        ECU_EDGE_OFF  = 2'd0,
        ECU_EDGE_RISE = 2'd1,
        ECU_EDGE_FALL = 2'd2,
        ECU_EDGE_BOTH = 2'd3
    } ecu_edge_e;

endpackage

// File: rtl/ecu_timebase.sv
module ecu_timebase
    import ecu_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PS_W  = ECU_PS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PS_W-1:0]  prescale,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [PS_W-1:0]  div;
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (!run) begin
            tb_d.div = '0;
        end else if (tb_q.div >= prescale) begin
            tb_d.div = '0;
            tb_d.cnt = tb_q.cnt + 1'b1;
        end else begin
            tb_d.div = tb_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign count = tb_q.cnt;

    AST_CNT_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count)); // R4

    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (count == $past(count) + 1'b1)); // R4

endmodule

// File: rtl/ecu_chan.sv
module ecu_chan
    import ecu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             run,
    input  ecu_edge_e        mode,
    input  logic [CNT_W-1:0] count,
    output logic             hit,
    output logic [CNT_W-1:0] cap
);

    typedef struct packed {
        logic [1:0]       sync;
        logic             last;
        logic [CNT_W-1:0] cap;
    } ch_state_t;

    ch_state_t ch_d, ch_q;
    logic rise, fall, sel;

    always_comb begin
        ch_d      = ch_q;
        rise      = ch_q.sync[1] & ~ch_q.last;
        fall      = ~ch_q.sync[1] & ch_q.last;
        unique case (mode)
            ECU_EDGE_RISE: sel = rise;
            ECU_EDGE_FALL: sel = fall;
            ECU_EDGE_BOTH: sel = rise | fall;
            default:       sel = 1'b0;
        endcase
        hit       = run & sel;
        ch_d.sync = {ch_q.sync[0], pin};
        ch_d.last = ch_q.sync[1];
        if (hit) ch_d.cap = count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign cap = ch_q.cap;

    AST_CAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cap == $past(count))); // R3

    AST_STOPPED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cap)); // R5

    AST_MODE_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ECU_EDGE_OFF) |=> $stable(cap)); // R2

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecu_pkg::*;
#(
    parameter int NUM_CH = ECU_MAX_CH,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] cap_in,
    output logic              irq
);

    localparam int PS_W = ECU_PS_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ECU_ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(ECU_ADDR_IEN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ECU_ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(ECU_ADDR_ACK);

    typedef struct packed {
        logic                   run;
        logic [PS_W-1:0]        presc;
        logic [NUM_CH-1:0]      ien;
        logic [NUM_CH-1:0]      stat;
        logic [NUM_CH-1:0][1:0] mode;
    } rg_state_t;

    rg_state_t rg_d, rg_q;

    logic [CNT_W-1:0]             count;
    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0][CNT_W-1:0] cap_val;
    logic [NUM_CH-1:0]            ack_mask;
    logic                         unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata;

    ecu_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (rg_q.run),
        .prescale (rg_q.presc),
        .count    (count)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ecu_chan #(.CNT_W(CNT_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cap_in[c]),
            .run   (rg_q.run),
            .mode  (ecu_edge_e'(rg_q.mode[c])),
            .count (count),
            .hit   (hit[c]),
            .cap   (cap_val[c])
        );

        AST_STAT_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            hit[c] |=> rg_q.stat[c]); // R6

        AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_ACK && bus_wdata[ECU_FLAG_LSB + c] && !hit[c])
            |=> !rg_q.stat[c]); // R7

        AST_FLAG_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit[c] && !(bus_we && bus_addr == A_ACK)) |=> $stable(rg_q.stat[c])); // R8
    end

    // Next-state for the register file
    always_comb begin
        rg_d     = rg_q;
        ack_mask = '0;
        if (bus_we) begin
            if (bus_addr == A_CTRL) begin
                rg_d.run   = bus_wdata[ECU_RUN_BIT];
                rg_d.presc = bus_wdata[ECU_PS_LSB +: PS_W];
            end
            if (bus_addr == A_IEN) begin
                rg_d.ien = bus_wdata[ECU_FLAG_LSB +: NUM_CH];
            end
            if (bus_addr == A_ACK) begin
                ack_mask = bus_wdata[ECU_FLAG_LSB +: NUM_CH];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == ADDR_W'(ECU_ADDR_EDGE + 4 * c)) begin
                    rg_d.mode[c] = bus_wdata[1:0];
                end
            end
        end
        // a new capture outranks a clear in the same cycle
        rg_d.stat = (rg_q.stat & ~ack_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[ECU_RUN_BIT]          = rg_q.run;
            bus_rdata[ECU_PS_LSB +: PS_W]   = rg_q.presc;
        end
        if (bus_addr == A_IEN)  bus_rdata[ECU_FLAG_LSB +: NUM_CH] = rg_q.ien;
        if (bus_addr == A_STAT) bus_rdata[ECU_FLAG_LSB +: NUM_CH] = rg_q.stat;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(ECU_ADDR_CAP + 4 * c)) begin
                bus_rdata = DATA_W'(cap_val[c]);
            end
            if (bus_addr == ADDR_W'(ECU_ADDR_EDGE + 4 * c)) begin
                bus_rdata[1:0] = rg_q.mode[c];
            end
        end
    end

    assign irq = |(rg_q.stat & rg_q.ien);

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.ien == '0) |-> !irq); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.stat == '0) |-> !irq); // R6

endmodule

// File: tb/edge_capture_unit_bench.sv
module edge_capture_unit_bench;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] cap_in = '0;
    logic        irq;

    always #10 clk = ~clk;

    edge_capture_unit u_edge_capture_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .irq       (irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Independent model of the time base (R4)
    logic        m_run = 1'b0;
    logic [4:0]  m_ps  = '0;
    logic [4:0]  m_div = '0;
    logic [31:0] m_cnt = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 1'b0; m_ps <= '0; m_div <= '0; m_cnt <= '0;
        end else begin
            if (m_run) begin
                if (m_div >= m_ps) begin m_div <= '0; m_cnt <= m_cnt + 1; end
                else m_div <= m_div + 1;
            end else begin
                m_div <= '0;
            end
            if (bus_we && bus_addr == 8'h50) begin
                m_run <= bus_wdata[10];
                m_ps  <= bus_wdata[8:4];
            end
        end
    end

    typedef struct { int ch; logic [31:0] val; string tag; } exp_t;
    exp_t sb[$];

    logic [31:0]    shadow_cap [NCH];
    logic [NCH-1:0] shadow_stat = '0;
    logic [NCH-1:0] shadow_ien  = '0;

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Driver: move one pin, push the expected timestamp if a capture is due
    task automatic edge_to(int ch, logic lvl, bit cap, string tag);
        @(negedge clk);
        cap_in[ch] = lvl;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        if (cap) begin
            sb.push_back('{ch, m_cnt, tag});
            shadow_cap[ch]  = m_cnt;
            shadow_stat[ch] = 1'b1;
        end
        @(posedge clk);
    endtask

    // Monitor: pop expected timestamps and compare with the design
    task automatic drain();
        logic [31:0] v;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            rd(8'(8'h10 + 4 * e.ch), v);
            check_eq(e.tag, v, e.val);
        end
    endtask

    task automatic check_all(string tag);
        logic [31:0] v;
        for (int c = 0; c < NCH; c++) begin
            rd(8'(8'h10 + 4 * c), v);
            check_eq({tag, " capture word"}, v, shadow_cap[c]);
        end
        rd(8'h58, v);
        check_eq({tag, " status"}, v, {27'd0, shadow_stat, 1'b0});
        @(negedge clk);
        #1 check_eq({tag, " irq"}, {31'd0, irq}, {31'd0, |(shadow_stat & shadow_ien)});
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < NCH; c++) shadow_cap[c] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(8'h50, v); check_eq("R1 control", v, 0);
        rd(8'h54, v); check_eq("R1 mask", v, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(8'(8'h30 + 4 * c), v); check_eq("R1 select", v, 0);
        end
        check_all("R1");

        // Start time base, divider 0; program codes (R2)
        wr(8'h50, 32'h400);
        wr(8'h30, 1); wr(8'h34, 2); wr(8'h38, 3); wr(8'h3C, 0);
        rd(8'h30, v); check_eq("R2 readback ch0", v, 1);
        rd(8'h34, v); check_eq("R2 readback ch1", v, 2);
        rd(8'h38, v); check_eq("R2 readback ch2", v, 3);

        // R3: rising capture on ch0, mask off keeps irq low (R6)
        edge_to(0, 1'b1, 1'b1, "R3 ch0 rise timestamp"); drain();
        check_all("R6 masked");
        // R2: falling ignored by rise-only code
        edge_to(0, 1'b0, 1'b0, ""); check_all("R2 fall ignored ch0");
        // R2: fall-only channel, R8 isolation
        edge_to(1, 1'b1, 1'b0, ""); check_all("R2 rise ignored ch1");
        edge_to(1, 1'b0, 1'b1, "R2 ch1 fall timestamp"); drain();
        check_all("R8 other channels");
        // R2: both edges
        edge_to(2, 1'b1, 1'b1, "R2 ch2 both rise"); drain();
        edge_to(2, 1'b0, 1'b1, "R2 ch2 both fall"); drain();
        // R2: code 0 ignores everything
        edge_to(3, 1'b1, 1'b0, ""); edge_to(3, 1'b0, 1'b0, "");
        check_all("R2 code off ch3");

        // R6: interrupt masking
        wr(8'h54, 32'h2); shadow_ien = 4'b0001; check_all("R6 ch0 enabled");
        wr(8'h54, 32'h10); shadow_ien = 4'b1000; check_all("R6 ch3 only");
        wr(8'h54, 32'h1E); shadow_ien = 4'b1111;

        // R7: acknowledge
        wr(8'h5C, 32'h0); check_all("R7 zero write");
        wr(8'h5C, 32'h2); shadow_stat[0] = 1'b0; check_all("R7 clear ch0");
        wr(8'h5C, 32'h1FF); shadow_stat = '0; check_all("R7 clear all");

        // R7: capture and clear in the same cycle, flag survives
        @(negedge clk); cap_in[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        sb.push_back('{0, m_cnt, "R7 same-cycle timestamp"});
        shadow_cap[0] = m_cnt; shadow_stat[0] = 1'b1;
        bus_we = 1'b1; bus_addr = 8'h5C; bus_wdata = 32'h2;
        @(negedge clk); bus_we = 1'b0;
        drain(); check_all("R7 set beats clear");

        // R2: XOR flip turns rise into fall
        rd(8'h30, v); wr(8'h30, v ^ 32'h3);
        rd(8'h30, v); check_eq("R2 flipped code", v, 2);
        edge_to(0, 1'b0, 1'b1, "R2 flipped fall timestamp"); drain();

        // R4: divider value 3
        wr(8'h50, 32'h400 | (3 << 4));
        edge_to(0, 1'b1, 1'b0, "");
        repeat (5) @(posedge clk);
        edge_to(0, 1'b0, 1'b1, "R4 divided timestamp A"); drain();
        repeat (9) @(posedge clk);
        edge_to(0, 1'b1, 1'b0, "");
        edge_to(0, 1'b0, 1'b1, "R4 divided timestamp B"); drain();

        // R5: stopped time base ignores edges
        wr(8'h50, 32'h030);
        wr(8'h5C, 32'h1FF); shadow_stat = '0;
        edge_to(0, 1'b1, 1'b0, "");
        edge_to(0, 1'b0, 1'b0, "");
        edge_to(2, 1'b1, 1'b0, "");
        check_all("R5 stopped");
        repeat (7) @(posedge clk);
        // R4: count held while stopped, resumes from there
        wr(8'h50, 32'h430);
        edge_to(0, 1'b1, 1'b0, "");
        edge_to(0, 1'b0, 1'b1, "R4 resume timestamp"); drain();
        check_all("R8 final");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule